// File: doc/BRIEF.md
# Byte-Port Reset Control Register

This block is a one-byte register mapped at a single I/O port address. Software writes it to either ask for a full system reset or to record which kind of reset (soft or hard) a later reset should be. A write with the trigger bit (bit 2) set raises a reset request and leaves the stored byte alone. A write with bit 2 clear keeps only the reset-type bit (bit 1) and stores zero in every other position.

The reset request leaves the block as a pulse of programmable length, so a downstream reset sequencer always sees a clean request of known width. The stored reset-type bit is also exported as a level, so that sequencer can pick soft or hard reset without a bus read. Accesses to any other port address are ignored. Reads of the port return the stored byte one cycle after the read strobe, with a valid flag.

Top module: `rst_ctl_port`

## Requirements
- R1: After reset the stored byte is 0x00, `rst_type_hard` is low, `sys_rst_req` is low, `io_rvalid` is low and `io_rdata` is 0x00.
- R2: A write to `PORT_ADDR` with data bit 2 clear stores data bit 1 in bit 1 and zero in all other bits; `rst_type_hard` shows the new bit from the cycle after the write strobe.
- R3: A write to `PORT_ADDR` with data bit 2 set, while no request is active, raises `sys_rst_req` in the cycle after the write strobe and leaves the stored byte unchanged, whatever the other data bits are.
- R4: A request keeps `sys_rst_req` high for exactly `PULSE_LEN` consecutive cycles (default 8), then low.
- R5: A trigger write while `sys_rst_req` is high neither lengthens nor restarts the pulse, and does not change the stored byte.
- R6: Writes to any address other than `PORT_ADDR` change neither the stored byte nor `sys_rst_req`.
- R7: A read strobe at `PORT_ADDR` gives `io_rvalid` high for one cycle in the following cycle with `io_rdata` equal to the stored byte, so only bit 1 can read as one; a read strobe at any other address leaves `io_rvalid` low and `io_rdata` 0x00.
- R8: When a read and a write of `PORT_ADDR` happen in the same cycle, the read returns the byte stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| io_addr | input | ADDR_W | I/O port address of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte access |
| io_rd | input | 1 | Read strobe, one cycle per byte access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid with `io_rvalid`, 0x00 otherwise |
| io_rvalid | output | 1 | High one cycle after a read strobe at the port address |
| sys_rst_req | output | 1 | System reset request pulse, `PULSE_LEN` cycles wide |
| rst_type_hard | output | 1 | Stored reset-type bit (1 = hard reset requested) |

## Verification
A corrupted stored byte shows immediately on `rst_type_hard` and, one cycle after a read strobe, in `io_rdata`; any bit other than bit 1 reading as one exposes a masking fault on the first readback. A wrong pulse counter shows as a request that starts late, ends early or late, or stretches when retriggered, which the bench measures cycle by cycle from the trigger write. A decode fault shows as a stored-value change or a request after a write to a neighbouring address, or as a valid read at the wrong address, all visible within one cycle.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned TYPE_BIT = 1;
  localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'(1) << TYPE_BIT;

  typedef struct packed {
    logic              rd_hit;
    logic              wr_store;
    logic              wr_trig;
    logic [BYTE_W-1:0] store_byte;
  } acc_dec_t;
endpackage

// File: rtl/rc_port_decode.sv
module rc_port_decode
  import rst_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h0CF9)
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [BYTE_W-1:0] io_wdata,
  output acc_dec_t          dec
);
  logic addr_match;

  always_comb begin
    addr_match     = (io_addr == PORT_ADDR);
    dec.rd_hit     = io_rd & addr_match;
    // Trigger and store are mutually exclusive per write.
    dec.wr_trig    = io_wr & addr_match & io_wdata[TRIG_BIT];
    dec.wr_store   = io_wr & addr_match & ~io_wdata[TRIG_BIT];
    dec.store_byte = io_wdata & KEEP_MASK;
  end
endmodule

// File: rtl/rc_type_reg.sv
module rc_type_reg
  import rst_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_dec_t          dec,
  output logic [BYTE_W-1:0] val_q,
  output logic [BYTE_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic [BYTE_W-1:0] val_d;
  logic [BYTE_W-1:0] rdata_d;
  logic              rvalid_d;
  logic              val_en;
  logic              rd_en;

  always_comb begin
    val_en   = dec.wr_store;
    val_d    = dec.store_byte;
    // Read sees the value held before any same-cycle write.
    rd_en    = dec.rd_hit | rvalid_q;
    rvalid_d = dec.rd_hit;
    rdata_d  = dec.rd_hit ? val_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else if (rd_en) begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end
endmodule

// File: rtl/rc_pulse_stretch.sv
module rc_pulse_stretch #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             busy;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = busy | fire;
    if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);   // retrigger ignored while counting
    end else begin
      cnt_d = LOAD_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse = busy;
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rst_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h0CF9),
  parameter int unsigned       PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              sys_rst_req,
  output logic              rst_type_hard
);
  acc_dec_t          dec;
  logic [BYTE_W-1:0] val_q;

  rc_port_decode #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .dec     (dec)
  );

  rc_type_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec     (dec),
    .val_q   (val_q),
    .rdata_q (io_rdata),
    .rvalid_q(io_rvalid)
  );

  rc_pulse_stretch #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (dec.wr_trig),
    .pulse(sys_rst_req)
  );

  assign rst_type_hard = val_q[TYPE_BIT];
endmodule

// File: rtl/rst_ctl_port_chk.sv
module rst_ctl_port_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h0CF9),
  parameter int unsigned       PULSE_LEN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              sys_rst_req,
  input logic              rst_type_hard
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_q;
  logic          hit;
  logic [7:0]    kept;

  assign hit  = (io_addr == PORT_ADDR);
  assign kept = io_wdata & 8'h02;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_q <= '0;
    else if (sys_rst_req) hi_q <= hi_q + HW'(1);
    else                  hi_q <= '0;
  end

  a_r2_store_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && !io_wdata[2]) |=> (rst_type_hard == $past(kept[1])));

  a_r3_trig_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_wdata[2]) |=> $stable(rst_type_hard));

  a_r3_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_wdata[2] && !sys_rst_req) |=> sys_rst_req);

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> (hi_q == HW'(PULSE_LEN)));

  a_r5_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (hi_q < HW'(PULSE_LEN)));

  a_r6_miss_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit) |=> $stable(rst_type_hard));

  a_r6_miss_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_req && !(io_wr && hit)) |=> !sys_rst_req);

  a_r7_miss_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && hit) |=> (!io_rvalid && io_rdata == 8'h00));

  a_r7_only_type_bit: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> ((io_rdata & 8'hFD) == 8'h00));

  a_r8_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit) |=> (io_rvalid && io_rdata[1] == $past(rst_type_hard)));
endmodule

bind rst_ctl_port rst_ctl_port_chk #(
  .ADDR_W   (ADDR_W),
  .PORT_ADDR(PORT_ADDR),
  .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .io_rvalid    (io_rvalid),
  .sys_rst_req  (sys_rst_req),
  .rst_type_hard(rst_type_hard)
);

// File: tb/rst_ctl_port_tb.sv
module rst_ctl_port_tb;
  localparam int unsigned ADDR_W    = 16;
  localparam logic [15:0] PORT      = 16'h0CF9;
  localparam int unsigned PULSE_LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        sys_rst_req;
  logic        rst_type_hard;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rst_ctl_port #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT), .PULSE_LEN(PULSE_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .sys_rst_req(sys_rst_req), .rst_type_hard(rst_type_hard));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when the design returns read data.
  always @(negedge clk) begin
    if (rst_n && io_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected rvalid", 1, 0);
      end else begin
        chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [7:0] exp);
    @(negedge clk);
    io_addr = PORT; io_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // Counts high cycles of the request from now on.
  task automatic measure(input string tag, input int exp_len, input bit retrig);
    int n = 0;
    while (sys_rst_req && n < 100) begin
      n++;
      if (retrig && n == 3) begin
        io_addr = PORT; io_wdata = 8'h04; io_wr = 1'b1;  // bit1 clear
      end
      if (retrig && n == 4) io_wr = 1'b0;
      @(negedge clk);
    end
    chk(tag, n, exp_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", io_rdata, 0);
    chk("R1 rvalid", io_rvalid, 0);
    chk("R1 req", sys_rst_req, 0);
    chk("R1 type", rst_type_hard, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R1 stored byte after reset", 8'h00);

    // R2: keep bit1 only
    do_write(PORT, 8'hFB);
    chk("R2 type after 0xFB", rst_type_hard, 1);
    do_read("R2 readback 0xFB", 8'h02);
    do_write(PORT, 8'hF9);
    chk("R2 type after 0xF9", rst_type_hard, 0);
    do_read("R2 readback 0xF9", 8'h00);
    do_write(PORT, 8'h02);
    do_read("R2 readback 0x02", 8'h02);

    // R3, R4: trigger with bit1 clear keeps stored 0x02
    do_write(PORT, 8'hF4);
    chk("R3 req next cycle", sys_rst_req, 1);
    chk("R3 type unchanged", rst_type_hard, 1);
    measure("R4 pulse length", PULSE_LEN, 1'b0);
    do_read("R3 stored unchanged", 8'h02);

    // R5: retrigger during pulse, with bit1 clear in data
    do_write(PORT, 8'h04);
    measure("R5 pulse not stretched", PULSE_LEN, 1'b1);
    chk("R5 type unchanged", rst_type_hard, 1);
    @(negedge clk);
    chk("R5 no restart", sys_rst_req, 0);

    // R6: neighbours ignored
    do_write(16'h0CF8, 8'h00);
    chk("R6 store miss", rst_type_hard, 1);
    do_write(16'h0CFA, 8'h04);
    chk("R6 trig miss", sys_rst_req, 0);
    @(negedge clk);
    chk("R6 trig miss later", sys_rst_req, 0);
    do_read("R6 value intact", 8'h02);

    // R7: read at another address
    @(negedge clk);
    io_addr = 16'h0CF8; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk("R7 miss rvalid", io_rvalid, 0);
    chk("R7 miss rdata", io_rdata, 0);

    // R8: same-cycle read and write
    @(negedge clk);
    io_addr = PORT; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
    exp_q.push_back(8'h02); tag_q.push_back("R8 read returns old value");
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk("R8 new value stored", rst_type_hard, 0);
    do_read("R8 later read", 8'h00);

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule